// File: doc/BRIEF.md
# Partitioned Wide Binary Counter

This block is a wide synchronous up-counter built from several narrow lanes, each the same width. Only the lowest lane counts at the full clock rate. Each higher lane steps by one only on an edge where every lane below it holds all ones. The critical path at clock rate therefore stays the width of one lane plus a short carry term, however wide the whole counter is. Each lane keeps a registered "full" flag, so the carry into a higher lane comes from flops and does not pass through the lower lanes' adders.

A single count-enable input gates the whole structure. The outputs are the concatenated count, with lane 0 in the least significant bits, and a terminal flag. The terminal flag shows in the cycle before the counter returns to zero. The lane width and the lane count are parameters. A higher lane holds its value for long stretches, so its increment logic can be given a multi-cycle timing budget.

Top module: `split_counter`

## Requirements
- R1: A synchronous reset clears the whole count to zero at the next rising edge, and the terminal flag is low while the count is zero.
- R2: With the enable high, each rising edge raises the concatenated count by exactly one, modulo 2^(SEG_W*SEG_N).
- R3: With the enable low, the count holds its value at every edge and the terminal flag stays low, even when the count is all ones.
- R4: Lane 0 steps on every enabled edge. Lane k (k ≥ 1) changes only on an enabled edge where lanes 0 to k-1 all hold all ones. It then steps by exactly one, and this happens once every 2^(SEG_W*k) enabled cycles.
- R5: The carry into lane k requires every lower lane to be full, not just lane k-1. The concatenated count never skips or repeats a value.
- R6: The terminal flag is high in exactly those cycles where the enable is high and every count bit is one. The count is zero after the following edge.
- R7: Over 2^(SEG_W*SEG_N) consecutive enabled cycles starting from zero, count bit n changes value exactly 2^(SEG_W*SEG_N-n) times. In other words, bit n completes one full period every 2^(n+1) enabled cycles.
- R8: A reset taken while several lanes are full also clears every lane's full flag. Counting that resumes afterwards starts at zero with no early carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| srst_i | input | 1 | Synchronous reset, active high |
| step_en_i | input | 1 | Count enable |
| value_o | output | SEG_W*SEG_N | Concatenated count, lane 0 in the low bits |
| last_o | output | 1 | Terminal flag: enabled and count all ones |

## Verification
The count is registered. A change of enable or reset applied before a rising edge shows on value_o right after that edge. The terminal flag is combinational from the current count and the enable, so it is valid in the same cycle the enable is applied. The driver applies inputs at the falling edge. It then pushes the expected count, meaning the value left by the previous rising edge, together with the expected flag for the inputs just applied. The monitor compares both one nanosecond later, before the next rising edge can move them. The bit-change test samples the count at the same point in each cycle and counts transitions over one full wrap.

// File: rtl/split_cnt_pkg.sv
`timescale 1ns/1ps
package split_cnt_pkg;

  // Total bit count of a counter made of n lanes of w bits.
  function automatic int total_bits(input int w, input int n);
    return w * n;
  endfunction

  // Enabled cycles between two steps of lane k.
  function automatic longint unsigned lane_period(input int w, input int k);
    return 64'd1 << (w * k);
  endfunction

endpackage

// File: rtl/split_cnt_lane.sv
`timescale 1ns/1ps
module split_cnt_lane #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         srst_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         full_o
);
  localparam logic [W-1:0] LANE_ONES = {W{1'b1}};
  localparam logic [W-1:0] LANE_PRE  = LANE_ONES - W'(1);

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  function automatic logic at_pre(input logic [W-1:0] v);
    return v == LANE_PRE;
  endfunction

  // The full flag is set one step early, so it is a flop output
  // exactly when the lane holds all ones.
  always_ff @(posedge clk_i) begin
    if (srst_i) begin
      val_o  <= '0;
      full_o <= 1'b0;
    end else if (inc_i) begin
      val_o  <= bump(val_o);
      full_o <= at_pre(val_o);
    end
  end

  AST_FLAG_TRACKS: assert property (@(posedge clk_i) disable iff (srst_i)
    full_o == (val_o == LANE_ONES)); // R5

  AST_LANE_HOLD: assert property (@(posedge clk_i) disable iff (srst_i)
    !inc_i |=> $stable(val_o)); // R4

endmodule

// File: rtl/split_cnt_carry.sv
`timescale 1ns/1ps
module split_cnt_carry #(
  parameter int N = 4
) (
  input  logic         en_i,
  input  logic [N-1:0] full_i,
  output logic [N-1:0] inc_o,
  output logic         tc_o
);
  // below[k]: every lane under k is full.
  logic [N:0] below;

  assign below[0] = 1'b1;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign below[k+1] = below[k] & full_i[k];
    assign inc_o[k]   = en_i & below[k];
  end

  assign tc_o = en_i & below[N];

endmodule

// File: rtl/split_counter.sv
`timescale 1ns/1ps
module split_counter #(
  parameter int SEG_W = 4,
  parameter int SEG_N = 4
) (
  input  logic                                            clk_i,
  input  logic                                            srst_i,
  input  logic                                            step_en_i,
  output logic [split_cnt_pkg::total_bits(SEG_W,SEG_N)-1:0] value_o,
  output logic                                            last_o
);
  localparam int TOT = split_cnt_pkg::total_bits(SEG_W, SEG_N);

  logic [SEG_N-1:0] lane_inc;
  logic [SEG_N-1:0] lane_full;
  logic [SEG_W-1:0] lane_val [SEG_N];

  split_cnt_carry #(.N(SEG_N)) u_carry (
    .en_i   (step_en_i),
    .full_i (lane_full),
    .inc_o  (lane_inc),
    .tc_o   (last_o)
  );

  for (genvar k = 0; k < SEG_N; k++) begin : g_lane
    split_cnt_lane #(.W(SEG_W)) u_lane (
      .clk_i  (clk_i),
      .srst_i (srst_i),
      .inc_i  (lane_inc[k]),
      .val_o  (lane_val[k]),
      .full_o (lane_full[k])
    );
    assign value_o[k*SEG_W +: SEG_W] = lane_val[k];

    if (k > 0) begin : g_upper
      // Enabled cycles seen since this lane last stepped.
      logic [TOT-1:0] gap_q;
      always_ff @(posedge clk_i) begin
        if (srst_i)           gap_q <= '0;
        else if (lane_inc[k]) gap_q <= '0;
        else if (step_en_i)   gap_q <= gap_q + TOT'(1);
      end

      AST_UPPER_NEEDS_LOWER: assert property (@(posedge clk_i) disable iff (srst_i)
        lane_inc[k] |-> (&value_o[k*SEG_W-1:0])); // R5

      AST_UPPER_PERIOD: assert property (@(posedge clk_i) disable iff (srst_i)
        lane_inc[k] |-> gap_q == TOT'(split_cnt_pkg::lane_period(SEG_W, k) - 64'd1)); // R4
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    srst_i |=> value_o == '0); // R1

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (srst_i)
    step_en_i |=> value_o == $past(value_o) + TOT'(1)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (srst_i)
    !step_en_i |=> $stable(value_o)); // R3

  AST_IDLE_NO_TC: assert property (@(posedge clk_i) disable iff (srst_i)
    !step_en_i |-> !last_o); // R3

  AST_TC_FULL: assert property (@(posedge clk_i) disable iff (srst_i)
    last_o |-> (&value_o)); // R6

  AST_TC_WRAP: assert property (@(posedge clk_i) disable iff (srst_i)
    last_o |=> value_o == '0); // R6

endmodule

// File: tb/sim_split_counter.sv
`timescale 1ns/1ps
module sim_split_counter;
  localparam int SW  = 2;
  localparam int SN  = 3;
  localparam int TOT = SW * SN;
  localparam logic [TOT-1:0] MAXV = {TOT{1'b1}};

  typedef struct {
    logic [TOT-1:0] cnt;
    logic           tc;
    string          tag;
  } item_t;

  logic           clk = 1'b0;
  logic           srst;
  logic           step_en;
  logic [TOT-1:0] value;
  logic           last;

  item_t          sb[$];
  logic [TOT-1:0] ref_cnt;
  int             checks = 0;
  int             errors = 0;

  always #2.5 clk = ~clk;

  split_counter #(.SEG_W(SW), .SEG_N(SN)) u0 (
    .clk_i     (clk),
    .srst_i    (srst),
    .step_en_i (step_en),
    .value_o   (value),
    .last_o    (last)
  );

  task automatic step(input logic en, input string tag);
    item_t it;
    @(negedge clk);
    srst    = 1'b0;
    step_en = en;
    it.cnt  = ref_cnt;
    it.tc   = en && (ref_cnt == MAXV);
    it.tag  = tag;
    sb.push_back(it);
    if (en) ref_cnt = ref_cnt + 1'b1;
  endtask

  task automatic do_reset(input string tag);
    item_t it;
    @(negedge clk);
    srst    = 1'b1;
    step_en = 1'b0;
    it.cnt  = ref_cnt;
    it.tc   = 1'b0;
    it.tag  = tag;
    sb.push_back(it);
    ref_cnt = '0;
  endtask

  // Monitor: compares each queued expectation shortly after the falling edge.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (value !== it.cnt) begin
          errors++;
          $display("FAIL %s count actual=%0d expected=%0d", it.tag, value, it.cnt);
        end
        checks++;
        if (last !== it.tc) begin
          errors++;
          $display("FAIL R6 (%s) terminal flag actual=%b expected=%b", it.tag, last, it.tc);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [TOT-1:0] prev;
    logic [TOT-1:0] cur;
    int             flips [TOT];
    srst    = 1'b1;
    step_en = 1'b0;
    ref_cnt = '0;
    repeat (3) @(posedge clk);

    // R1: state under reset
    do_reset("R1");
    step(1'b1, "R1");

    // R2 R4: free run through three full wraps
    for (int i = 0; i < 200; i++) step(1'b1, "R2");

    // R3: hold with enable low, then at all ones
    for (int i = 0; i < 10; i++) step(1'b0, "R3");
    while (ref_cnt != MAXV) step(1'b1, "R4");
    for (int i = 0; i < 5; i++) step(1'b0, "R3");
    step(1'b1, "R6");
    step(1'b1, "R6");

    // R5: random enable pattern across several wraps
    for (int i = 0; i < 320; i++) step($urandom_range(0, 3) != 0, "R5");

    // R8: reset taken with lanes 0 and 1 full
    while (ref_cnt != 6'd47) step(1'b1, "R8");
    do_reset("R8");
    for (int i = 0; i < 70; i++) step(1'b1, "R8");

    // R7: bit transitions across one full wrap from zero
    do_reset("R7");
    for (int b = 0; b < TOT; b++) flips[b] = 0;
    prev = '0;
    for (int i = 0; i < 65; i++) begin
      step(1'b1, "R7");
      #1;
      cur = value;
      if (i > 0)
        for (int b = 0; b < TOT; b++) if (cur[b] != prev[b]) flips[b]++;
      prev = cur;
    end
    for (int b = 0; b < TOT; b++) begin
      checks++;
      if (flips[b] != (64 >> b)) begin
        errors++;
        $display("FAIL R7 bit %0d changes actual=%0d expected=%0d", b, flips[b], 64 >> b);
      end
    end

    step(1'b0, "R3");
    repeat (3) @(negedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule